// File: doc/BRIEF.md
# Four-Channel Fractional Clock-Enable Generator

The block takes one fast source clock and produces four independent single-cycle enable streams. Each stream fires on average 18 times in every `D` source cycles, where `D` is a per-channel 6-bit divisor held in a shared control word. The effective divisor is limited to the range 18..35, so every stream runs somewhere between the full source rate and a little more than half of it. The streams are meant to qualify logic that sits in the source clock domain. They are not clocks themselves.

The four channels share one 32-bit control word, with one byte per channel. Channel `n` owns bits `[8n+7:8n]`. Inside a byte, bits `[5:0]` hold the divisor, bit 7 is an active-high stop bit, and bit 6 is reserved. The word can be replaced outright, OR-ed into through a set alias, or cleared bitwise through a clear alias. It is always visible on the read port, so software can do a read-modify-write of one channel without disturbing the other three.

Each channel is a phase accumulator. On every source cycle it adds 18. When the sum reaches the divisor, it subtracts the divisor and raises its enable for one cycle.

Top module: `frac_tick_gen`

## Requirements
- R1: After reset the control word reads 0x92929292 (every channel stopped, divisor 18) and all four enables are low.
- R2: A write with `wrAddr`=0 replaces the control word with `wrData`. Reserved bits are the only exception.
- R3: Bit 6 of every byte always reads 0, whatever value is written to it.
- R4: A write with `wrAddr`=1 ORs `wrData` into the control word.
- R5: A write with `wrAddr`=2 clears every control bit that is 1 in `wrData` and leaves the other bits unchanged.
- R6: A write with `wrAddr`=3 leaves the control word and all enables unaffected.
- R7: While bit 7 of a channel's byte is 1, that channel's enable is low and its phase is zero. After the bit is cleared, the channel restarts from zero phase. With divisor 27 its enable then reads 0,1,1,0 on the four cycles that follow the write edge.
- R8: A running channel updates once per cycle. It adds 18 to its phase. If the phase reaches the divisor, it subtracts the divisor and asserts the enable on the next cycle. Starting from zero phase, a window of `k*D` cycles therefore contains exactly `18*k` enables.
- R9: A running channel with effective divisor 18 has its enable high on every cycle.
- R10: A divisor field below 18 acts as 18, and a divisor field above 35 acts as 35.
- R11: A change to a running channel's divisor takes effect on the next phase update and does not reset the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, sampled on the rising edge |
| wrAddr | input | 2 | 0 = replace, 1 = set alias, 2 = clear alias, 3 = no effect |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Current control word |
| tickEn | output | 4 | Per-channel enable pulses, bit n for channel n |

## Verification
A write that lands on rising edge E is visible on `rdData` from E onward. The enables first reflect it one edge later, at E+1, because each enable is a register fed by the phase update that reads the control word. The bench drives every input on the falling edge and samples everything on the next falling edge. A behavioural model advanced at each rising edge is compared against both outputs on every cycle. Explicit checks for restart patterns and for rate counts begin counting from the E+1 sample.

// File: rtl/frac_tick_pkg.sv
package frac_tick_pkg;
  parameter int NUM_CH    = 4;
  parameter int LANE_W    = 8;
  parameter int DIV_W     = 6;
  parameter int STEP      = 18;
  parameter int DIV_MIN   = 18;
  parameter int DIV_MAX   = 35;
  parameter int ACC_W     = 7;
  parameter int STOP_BIT  = 7;
  localparam int WORD_W   = NUM_CH * LANE_W;

  localparam logic [1:0] ADDR_BASE = 2'd0;
  localparam logic [1:0] ADDR_SET  = 2'd1;
  localparam logic [1:0] ADDR_CLR  = 2'd2;

  typedef struct packed {
    logic             run;
    logic [DIV_W-1:0] divisor;
  } chanStrobe_t;
endpackage

// File: rtl/frac_tick_ctrl.sv
module frac_tick_ctrl
  import frac_tick_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [1:0]                     wrAddr,
  input  logic [WORD_W-1:0]              wrData,
  output logic [WORD_W-1:0]              ctrlWord,
  output chanStrobe_t [NUM_CH-1:0]       chanCfg
);
  localparam logic [LANE_W-1:0] LANE_MASK  = LANE_W'((1 << STOP_BIT) | ((1 << DIV_W) - 1));
  localparam logic [LANE_W-1:0] LANE_RESET = LANE_W'((1 << STOP_BIT) | DIV_MIN);
  localparam logic [WORD_W-1:0] WORD_MASK  = {NUM_CH{LANE_MASK}};
  localparam logic [WORD_W-1:0] WORD_RESET = {NUM_CH{LANE_RESET}};

  logic [WORD_W-1:0] wordQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ <= WORD_RESET;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_BASE: wordQ <= wrData & WORD_MASK;
        ADDR_SET:  wordQ <= (wordQ | wrData) & WORD_MASK;
        ADDR_CLR:  wordQ <= wordQ & ~wrData;
        default:   wordQ <= wordQ;
      endcase
    end
  end

  assign ctrlWord = wordQ;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
    logic [DIV_W-1:0] rawDiv;
    assign rawDiv = wordQ[i*LANE_W +: DIV_W];
    assign chanCfg[i].run = ~wordQ[i*LANE_W + STOP_BIT];
    always_comb begin
      if (rawDiv < DIV_W'(DIV_MIN))      chanCfg[i].divisor = DIV_W'(DIV_MIN);
      else if (rawDiv > DIV_W'(DIV_MAX)) chanCfg[i].divisor = DIV_W'(DIV_MAX);
      else                               chanCfg[i].divisor = rawDiv;
    end
  end

  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordQ & ~WORD_MASK) == '0);
  // R6
  ignored_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd3) |=> $stable(wordQ));
  // R5
  clear_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_CLR) |=> ((wordQ & $past(wrData)) == '0));
  // R4
  set_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_SET) |=> ((wordQ & ($past(wrData) & WORD_MASK)) == ($past(wrData) & WORD_MASK)));
endmodule

// File: rtl/frac_tick_datapath.sv
module frac_tick_datapath
  import frac_tick_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  chanStrobe_t [NUM_CH-1:0]  chanCfg,
  output logic [NUM_CH-1:0]         tickEn
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [ACC_W-1:0] phaseQ;
    logic [ACC_W-1:0] phaseSum;
    logic [ACC_W-1:0] divExt;
    logic             tickQ;

    assign phaseSum = phaseQ + ACC_W'(STEP);
    assign divExt   = ACC_W'(chanCfg[i].divisor);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        phaseQ <= '0;
        tickQ  <= 1'b0;
      end else if (!chanCfg[i].run) begin
        phaseQ <= '0;
        tickQ  <= 1'b0;
      end else if (phaseSum >= divExt) begin
        phaseQ <= phaseSum - divExt;
        tickQ  <= 1'b1;
      end else begin
        phaseQ <= phaseSum;
        tickQ  <= 1'b0;
      end
    end

    assign tickEn[i] = tickQ;

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
      phaseQ <= ACC_W'(DIV_MAX - 1));
    // R7
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      !chanCfg[i].run |=> (!tickQ && phaseQ == '0));
    // R9
    full_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
      (chanCfg[i].run && chanCfg[i].divisor == DIV_W'(DIV_MIN)) |=> tickQ);
    // R10
    div_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      chanCfg[i].divisor >= DIV_W'(DIV_MIN) && chanCfg[i].divisor <= DIV_W'(DIV_MAX));
  end
endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen
  import frac_tick_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic [3:0]  tickEn
);
  chanStrobe_t [NUM_CH-1:0] chanCfg;

  frac_tick_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .ctrlWord (rdData),
    .chanCfg  (chanCfg)
  );

  frac_tick_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .chanCfg (chanCfg),
    .tickEn  (tickEn)
  );
endmodule

// File: tb/tb_frac_tick_gen.sv
`timescale 1ns/1ps
module tb_frac_tick_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  tickEn;

  int nCmp = 0;
  int nBad = 0;
  string curReq = "R1";
  bit modelOn = 0;

  always #10 clk = ~clk;

  frac_tick_gen dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdData(rdData), .tickEn(tickEn)
  );

  // behavioural reference, advanced on each rising edge
  logic [31:0] mWord;
  int          mPhase [4];
  logic [3:0]  mTick;

  always @(posedge clk) begin
    if (!rstN) begin
      mWord = 32'h9292_9292;
      mTick = '0;
      foreach (mPhase[c]) mPhase[c] = 0;
    end else begin
      for (int c = 0; c < 4; c++) begin
        int d;
        d = mWord[8*c +: 6];
        if (d < 18) d = 18;
        if (d > 35) d = 35;
        if (mWord[8*c+7]) begin
          mPhase[c] = 0; mTick[c] = 1'b0;
        end else if (mPhase[c] + 18 >= d) begin
          mPhase[c] = mPhase[c] + 18 - d; mTick[c] = 1'b1;
        end else begin
          mPhase[c] = mPhase[c] + 18; mTick[c] = 1'b0;
        end
      end
      if (wrEn) begin
        case (wrAddr)
          2'd0: mWord = wrData & 32'hBFBF_BFBF;
          2'd1: mWord = (mWord | wrData) & 32'hBFBF_BFBF;
          2'd2: mWord = mWord & ~wrData;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (modelOn) begin
      check(curReq, "model rdData", rdData, mWord);
      check(curReq, "model tickEn", {28'd0, tickEn}, {28'd0, mTick});
    end
  end

  task automatic doWrite(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int cnt [4];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    modelOn = 1;
    check("R1", "reset word", rdData, 32'h9292_9292);
    check("R1", "reset enables", {28'd0, tickEn}, 32'd0);

    curReq = "R9";
    doWrite(2'd0, 32'h1212_1212);
    repeat (3) @(negedge clk);
    check("R9", "full rate", {28'd0, tickEn}, 32'hF);

    curReq = "R2";
    doWrite(2'd0, 32'hFFFF_FFFF);
    check("R3", "reserved bits", rdData, 32'hBFBF_BFBF);
    @(negedge clk);
    check("R7", "stopped enables", {28'd0, tickEn}, 32'd0);

    doWrite(2'd0, 32'h9292_9292);
    check("R2", "replace", rdData, 32'h9292_9292);

    curReq = "R4";
    doWrite(2'd1, 32'h0000_4009);
    check("R4", "set alias", rdData, 32'h9292_929B);

    curReq = "R7";
    doWrite(2'd2, 32'h0000_0080);
    check("R5", "clear alias", rdData, 32'h9292_921B);
    @(negedge clk); check("R7", "restart c1", {31'd0, tickEn[0]}, 32'd0);
    @(negedge clk); check("R7", "restart c2", {31'd0, tickEn[0]}, 32'd1);
    @(negedge clk); check("R7", "restart c3", {31'd0, tickEn[0]}, 32'd1);
    @(negedge clk); check("R7", "restart c4", {31'd0, tickEn[0]}, 32'd0);

    curReq = "R6";
    doWrite(2'd3, 32'hFFFF_FFFF);
    check("R6", "ignored addr", rdData, 32'h9292_921B);
    @(negedge clk);
    check("R6", "ignored addr gates", {28'd0, tickEn[3:1], 1'b0}, 32'd0);

    curReq = "R11";
    repeat (5) @(negedge clk);
    doWrite(2'd2, 32'h0000_0007);
    repeat (60) @(negedge clk);
    doWrite(2'd1, 32'h0000_0005);
    repeat (60) @(negedge clk);

    curReq = "R8";
    doWrite(2'd0, 32'h8080_8080);
    repeat (2) @(negedge clk);
    doWrite(2'd0, 32'h1E00_3F1B);
    foreach (cnt[c]) cnt[c] = 0;
    repeat (1890) begin
      @(negedge clk);
      for (int c = 0; c < 4; c++) if (tickEn[c]) cnt[c]++;
    end
    check("R8", "count div27", cnt[0], 32'd1260);
    check("R10", "count clamp hi", cnt[1], 32'd972);
    check("R10", "count clamp lo", cnt[2], 32'd1890);
    check("R8", "count div30", cnt[3], 32'd1134);

    finishRun();
  end
endmodule